// File: doc/BRIEF.md
# UART 16x Oversampling Tick Generator

This block turns the peripheral clock into the single-cycle strobe that paces a UART's transmit and receive shifters at sixteen times the baud rate. It has a reload counter that counts down and, by default, a fixed divide-by-two stage in front of it. With that stage in place the strobe period is 2 × (reload + 1) clock cycles, so software programs the reload value as half the oversampling divisor minus one. A control bit can take the divide-by-two stage out of the path, which gives a period of reload + 1. The highest rate is one strobe on every clock cycle: reload 0 with the stage bypassed, which equals the clock divided by 16 at the baud level.

The control word has three fields: a run enable, a prescaler bypass and a fractional-divider enable. The fractional path is not built. While its enable is set, the generator holds its count and emits nothing. A new reload value counts only through the run sequence. Software stops the generator, clears the fractional and bypass fields, writes the reload register and sets run again. The 0-to-1 edge of run copies the stored reload into the counter and into the active reload copy, and it clears the prescaler phase. A reload write made while the generator runs is kept but has no effect until the next start.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick16x` is 0, run is off and the stored reload value is 0. A start with no reload write therefore produces one tick on every cycle when the bypass is set.
- R2: While run is 0, `tick16x` stays 0. A control write that clears run forces `tick16x` low from the cycle after the write edge.
- R3: With `ctl_prediv_bypass` = 0 and fractional enable off, `tick16x` is a one-cycle pulse with a period of exactly 2 × (reload + 1) cycles.
- R4: With `ctl_prediv_bypass` = 1, the tick period is reload + 1 cycles. Reload 0 gives a tick on every cycle.
- R5: On a 0-to-1 change of run, the counter loads the stored reload value and the prescaler phase is cleared. The first tick therefore appears exactly one period after the starting write edge.
- R6: A write to `rld_wdata` while run is 1 does not change the running period. The value takes effect at the next 0-to-1 change of run, with no second reload write needed.
- R7: While `ctl_frac_en` = 1, no tick is produced and the counter and prescaler hold their state. Clearing the bit with run still 1 resumes the count without a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the three control fields |
| ctl_run | input | 1 | Run enable written on `ctl_we` |
| ctl_prediv_bypass | input | 1 | 1 removes the divide-by-two stage, written on `ctl_we` |
| ctl_frac_en | input | 1 | Fractional divider enable, written on `ctl_we` (1 holds the generator) |
| rld_we | input | 1 | Write strobe for the reload register |
| rld_wdata | input | RLD_W | Reload value |
| tick16x | output | 1 | One-cycle strobe at 16x the baud rate |

## Verification
The hardest case to reach from the ports is a reload write that lands in the middle of a running period. Only the period measured afterwards, and the period after a later restart, show whether the active copy was left alone. The bench drives that write one cycle into a measured run. It checks three more periods at the old value, then stops and restarts without writing again, and expects the new period. It also freezes the generator with the fractional enable at an arbitrary phase. It then counts ticks over a window that is a whole number of periods, so the result does not depend on where the counter stopped.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // Control state of the generator
  typedef struct packed {
    logic run;
    logic frac;
    logic byp;
  } bg_ctl_t;

  // Build the control word from the written fields
  function automatic bg_ctl_t pack_ctl(input logic run, input logic frac, input logic byp);
    bg_ctl_t c;
    c.run  = run;
    c.frac = frac;
    c.byp  = byp;
    return c;
  endfunction

  // Tick period in clock cycles for a reload value and prescaler choice
  function automatic int unsigned tick_period(input int unsigned rld, input logic byp);
    return byp ? (rld + 1) : (2 * (rld + 1));
  endfunction

  // Next count value of the reload counter on an enabled step
  function automatic logic [31:0] count_step(input logic [31:0] cur, input logic [31:0] rld);
    return (cur == 32'd0) ? rld : (cur - 32'd1);
  endfunction

endpackage

// File: rtl/bg_ctl_regs.sv
module bg_ctl_regs
  import baud_pkg::*;
#(
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ctl_frac,
  input  logic             ctl_byp,
  input  logic             rld_we,
  input  logic [RLD_W-1:0] rld_wdata,
  output bg_ctl_t          ctl_q,
  output bg_ctl_t          ctl_nxt,
  output logic             start,
  output logic [RLD_W-1:0] rld_q,
  output logic [RLD_W-1:0] active_rld
);

  bg_ctl_t ctl_new;

  assign ctl_new = pack_ctl(ctl_run, ctl_frac, ctl_byp);
  assign ctl_nxt = ctl_we ? ctl_new : ctl_q;
  // Rising edge of the run field
  assign start   = ctl_we & ctl_run & ~ctl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_new;
    end
  end

  // Stored reload: always writable, used only at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
    end else if (rld_we) begin
      rld_q <= rld_wdata;
    end
  end

  // Active reload copy: captured only on a start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_rld <= '0;
    end else if (start) begin
      active_rld <= rld_q;
    end
  end

endmodule

// File: rtl/bg_prescaler.sv
module bg_prescaler (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic byp,
  output logic en
);

  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (clr) begin
      phase_q <= 1'b0;
    end else if (adv && !byp) begin
      phase_q <= ~phase_q;
    end
  end

  assign en = adv & (byp | phase_q);

endmodule

// File: rtl/bg_reload_counter.sv
module bg_reload_counter
  import baud_pkg::*;
#(
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RLD_W-1:0] load_val,
  input  logic [RLD_W-1:0] reload_val,
  input  logic             step,
  output logic             term,
  output logic [RLD_W-1:0] cnt
);

  localparam int PAD_W = 32 - RLD_W;

  logic [31:0] nxt_wide;

  assign nxt_wide = count_step({{PAD_W{1'b0}}, cnt}, {{PAD_W{1'b0}}, reload_val});
  assign term     = step & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (step) begin
      cnt <= nxt_wide[RLD_W-1:0];
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ctl_prediv_bypass,
  input  logic             ctl_frac_en,
  input  logic             rld_we,
  input  logic [RLD_W-1:0] rld_wdata,
  output logic             tick16x
);

  bg_ctl_t          ctl_q;
  bg_ctl_t          ctl_nxt;
  logic             start_w;
  logic [RLD_W-1:0] rld_w;
  logic [RLD_W-1:0] active_w;
  logic [RLD_W-1:0] cnt_w;
  logic             adv_w;
  logic             step_w;
  logic             term_w;
  logic             run_w;
  logic             frac_w;
  logic             byp_w;
  logic             tick_q;

  assign run_w  = ctl_q.run;
  assign frac_w = ctl_q.frac;
  assign byp_w  = ctl_q.byp;
  assign adv_w  = run_w & ~frac_w;

  bg_ctl_regs #(.RLD_W(RLD_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_run    (ctl_run),
    .ctl_frac   (ctl_frac_en),
    .ctl_byp    (ctl_prediv_bypass),
    .rld_we     (rld_we),
    .rld_wdata  (rld_wdata),
    .ctl_q      (ctl_q),
    .ctl_nxt    (ctl_nxt),
    .start      (start_w),
    .rld_q      (rld_w),
    .active_rld (active_w)
  );

  bg_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_w),
    .adv   (adv_w),
    .byp   (byp_w),
    .en    (step_w)
  );

  bg_reload_counter #(.RLD_W(RLD_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_w),
    .load_val   (rld_w),
    .reload_val (active_w),
    .step       (step_w),
    .term       (term_w),
    .cnt        (cnt_w)
  );

  // Registered tick, squashed when this edge stops or freezes the generator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= term_w & ctl_nxt.run & ~ctl_nxt.frac;
    end
  end

  assign tick16x = tick_q;

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int RLD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ctl_we,
  input logic             rld_we,
  input logic             run_w,
  input logic             frac_w,
  input logic             byp_w,
  input logic             start_w,
  input logic             step_w,
  input logic [RLD_W-1:0] rld_w,
  input logic [RLD_W-1:0] active_w,
  input logic [RLD_W-1:0] cnt_w
);

  // R1: reset clears the tick and the run state
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!tick && !run_w));

  // R2: a tick needs run set at the edge that produced it
  p_no_tick_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(run_w));

  // R3: with the prescaler in the path, counter steps are never adjacent
  p_step_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !byp_w && !ctl_we) |=> !step_w);

  // R4: a tick only follows a terminal count
  p_tick_from_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(cnt_w == '0));

  // R5: a start loads the stored reload into the counter and the active copy
  p_start_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (cnt_w == $past(rld_w) && active_w == $past(rld_w)));

  // R6: a reload write while running leaves the active copy untouched
  p_run_reload_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_we && run_w) |=> (active_w == $past(active_w)));

  // R7: the fractional enable freezes the counter and blocks ticks
  p_frac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && frac_w) |=> $stable(cnt_w));

  p_frac_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !$past(frac_w));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.RLD_W(RLD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick16x),
  .ctl_we   (ctl_we),
  .rld_we   (rld_we),
  .run_w    (run_w),
  .frac_w   (frac_w),
  .byp_w    (byp_w),
  .start_w  (start_w),
  .step_w   (step_w),
  .rld_w    (rld_w),
  .active_w (active_w),
  .cnt_w    (cnt_w)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;

  localparam int RLD_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ctl_we = 1'b0;
  logic             ctl_run = 1'b0;
  logic             ctl_prediv_bypass = 1'b0;
  logic             ctl_frac_en = 1'b0;
  logic             rld_we = 1'b0;
  logic [RLD_W-1:0] rld_wdata = '0;
  logic             tick16x;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen #(.RLD_W(RLD_W)) u_dut (
    .clk               (clk),
    .rst_n             (rst_n),
    .ctl_we            (ctl_we),
    .ctl_run           (ctl_run),
    .ctl_prediv_bypass (ctl_prediv_bypass),
    .ctl_frac_en       (ctl_frac_en),
    .rld_we            (rld_we),
    .rld_wdata         (rld_wdata),
    .tick16x           (tick16x)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input int n);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: tick actual %b expected %b", tag, n, act, exp);
    end
  endtask

  // Control write; returns at the negedge just after the write edge (cycle 0)
  task automatic ctl_write(input logic run, input logic byp, input logic frac);
    @(negedge clk);
    ctl_we = 1'b1; ctl_run = run; ctl_prediv_bypass = byp; ctl_frac_en = frac;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic rld_write(input int v);
    @(negedge clk);
    rld_we = 1'b1; rld_wdata = RLD_W'(v);
    @(negedge clk);
    rld_we = 1'b0;
  endtask

  // Called in cycle 0 after a start: expect ticks exactly at multiples of p
  task automatic measure(input int p, input string tag, input bit mid, input int mid_val);
    chk(tick16x, 1'b0, tag, 0);
    for (int n = 1; n <= 3 * p; n++) begin
      @(negedge clk);
      if (mid && n == 1) begin rld_we = 1'b1; rld_wdata = RLD_W'(mid_val); end
      if (n == 2) rld_we = 1'b0;
      chk(tick16x, (n % p) == 0, tag, n);
    end
    rld_we = 1'b0;
  endtask

  task automatic stop_check(input string tag);
    ctl_write(1'b0, 1'b0, 1'b0);
    chk(tick16x, 1'b0, tag, 0);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      chk(tick16x, 1'b0, tag, n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int tcount;
    repeat (3) @(negedge clk);
    chk(tick16x, 1'b0, "R1 reset", 0);
    rst_n = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      chk(tick16x, 1'b0, "R2 idle after reset", n);
    end

    // R1: reset reload is 0, so bypass start ticks every cycle
    ctl_write(1'b1, 1'b1, 1'b0);
    measure(1, "R1 reset reload", 1'b0, 0);
    stop_check("R2 stop");

    // R3/R4/R5: sweep reload values in both prescaler modes
    for (int r = 0; r < 16; r++) begin
      for (int b = 0; b < 2; b++) begin
        rld_write(r);
        ctl_write(1'b1, b[0], 1'b0);
        if (b == 1) measure(r + 1, "R4 R5 bypass period", 1'b0, 0);
        else        measure(2 * (r + 1), "R3 R5 prescaled period", 1'b0, 0);
        stop_check("R2 stop");
      end
    end

    // R6: reload write while running is held until the next start
    rld_write(3);
    ctl_write(1'b1, 1'b1, 1'b0);
    measure(4, "R6 period kept", 1'b1, 9);
    ctl_write(1'b0, 1'b1, 1'b0);
    ctl_write(1'b1, 1'b1, 1'b0);
    measure(10, "R6 new period after restart", 1'b0, 0);
    stop_check("R2 stop");

    // R7: fractional enable freezes the generator, clearing it resumes
    rld_write(2);
    ctl_write(1'b1, 1'b1, 1'b0);
    measure(3, "R7 before freeze", 1'b0, 0);
    ctl_write(1'b1, 1'b1, 1'b1);
    chk(tick16x, 1'b0, "R7 frozen", 0);
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      chk(tick16x, 1'b0, "R7 frozen", n);
    end
    ctl_write(1'b1, 1'b1, 1'b0);
    tcount = 0;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (tick16x === 1'b1) tcount++;
    end
    checks++;
    if (tcount != 10) begin
      fails++;
      $display("FAIL R7 resume: tick count actual %0d expected %0d", tcount, 10);
    end
    stop_check("R2 final stop");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule